// File: doc/BRIEF.md
# Vectored Interrupt Response Unit

This unit sits next to a small processor core and decides when the core leaves its program for an interrupt handler. A set of request lines comes in. Some are external devices and some are internal exception flags. Together they form one pending condition. A global enable bit gates that condition, and the core's end-of-instruction strobe times the response. So the unit answers only at an instruction boundary.

When it takes an interrupt, the unit does four things in the same cycle. It acknowledges the winning source. It gives the core a new PC, computed as base plus source number times a fixed stride. It raises a push request that carries the return PC. For a source marked restartable, that return PC is rewound by one instruction so the faulting instruction runs again. On the following clock edge the unit records the cause lines, saves the status word, clears the enable bit and enters supervisor mode. A return command restores the saved status word, which re-arms interrupts.

The status word has two bits. Bit 0 is the interrupt enable and bit 1 is the supervisor flag. Software may write it only while in supervisor mode.

Top module: `irq_vector_unit`

## Requirements
- R1: The pending condition is the OR of all request lines. No interrupt is taken while every request line is low.
- R2: `take` is high in a cycle exactly when the enable bit (status bit 0) is set, `instr_done` is high and at least one request is pending. With the enable bit clear, or without `instr_done`, nothing is taken.
- R3: During a take cycle `ack` is one-hot at the winning source. Outside take cycles `ack` is zero.
- R4: Among simultaneous requests, the lowest-numbered line wins.
- R5: During a take cycle, `new_pc` equals `VEC_BASE + winner * VEC_STRIDE`.
- R6: `push_en` is high exactly in take cycles. For a source whose `RESTART_MASK` bit is 0, `push_data` equals `pc_next`.
- R7: For a source whose `RESTART_MASK` bit is 1, `push_data` equals `pc_next - 4`.
- R8: On the edge that ends a take cycle, `cause` captures every request line high in that cycle, so more than one bit may be set. At other times `cause` holds its value.
- R9: On the edge that ends a take cycle, the old status word is saved, the enable bit is cleared and the supervisor bit is set. No further take occurs until the enable bit is set again.
- R10: `rfi` outside a take cycle loads the status word from the saved copy on the next edge.
- R11: `csr_wr` loads `csr_wdata` into the status word only in supervisor mode. In user mode the write is ignored. `rfi` has priority over `csr_wr`, and a take has priority over both.
- R12: After reset the status word is 2'b10 (supervisor, interrupts disabled) and `cause` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | NSRC | Request lines, bit i is source i |
| instr_done | input | 1 | Core strobe: current instruction completes this cycle |
| pc_next | input | XLEN | Incremented PC of the completing instruction |
| rfi | input | 1 | Return-from-interrupt command |
| csr_wr | input | 1 | Status word write strobe |
| csr_wdata | input | 2 | Status word write value {supervisor, enable} |
| take | output | 1 | Interrupt taken this cycle |
| ack | output | NSRC | One-hot acknowledge to the winning source |
| new_pc | output | XLEN | Handler vector target |
| push_en | output | 1 | Request to push the return PC |
| push_data | output | XLEN | Return PC to push |
| cause | output | NSRC | Request lines captured at the last take |
| status | output | 2 | Status word {supervisor, enable} |

## Verification
A wrong enable bit shows up at once. Either a take fires that the scoreboard did not predict, or a predicted take never arrives, and both are seen on the first request presented at an instruction boundary. A wrong winner index is visible in the same cycle through `ack`, `new_pc` and `push_data` together. A corrupted status save, mode bit or cause capture appears on `status` or `cause` one edge after the take, after a return, or after a user-mode write.

// File: rtl/irq_vector_unit.sv
module irq_vector_unit #(
  parameter int NSRC = 8,
  parameter int XLEN = 32,
  parameter logic [XLEN-1:0] VEC_BASE = 32'h0000_1000,
  parameter int VEC_STRIDE = 16,
  parameter logic [NSRC-1:0] RESTART_MASK = 8'b0000_0011
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] req,
  input  logic            instr_done,
  input  logic [XLEN-1:0] pc_next,
  input  logic            rfi,
  input  logic            csr_wr,
  input  logic [1:0]      csr_wdata,
  output logic            take,
  output logic [NSRC-1:0] ack,
  output logic [XLEN-1:0] new_pc,
  output logic            push_en,
  output logic [XLEN-1:0] push_data,
  output logic [NSRC-1:0] cause,
  output logic [1:0]      status
);
  localparam int IDXW = (NSRC > 1) ? $clog2(NSRC) : 1;

  logic [1:0]      status_q, saved_q;
  logic [NSRC-1:0] cause_q;
  logic [IDXW-1:0] win;
  logic            pending;

  always_comb begin
    win = '0;
    for (int i = NSRC - 1; i >= 0; i--)
      if (req[i]) win = IDXW'(i);
  end

  assign pending   = |req;
  assign take      = status_q[0] & instr_done & pending;
  assign ack       = take ? (NSRC'(1) << win) : '0;
  assign new_pc    = VEC_BASE + XLEN'(win) * XLEN'(VEC_STRIDE);
  assign push_en   = take;
  assign push_data = RESTART_MASK[win] ? pc_next - XLEN'(4) : pc_next;
  assign cause     = cause_q;
  assign status    = status_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= 2'b10;
      saved_q  <= 2'b10;
      cause_q  <= '0;
    end else if (take) begin
      saved_q  <= status_q;
      status_q <= 2'b10;
      cause_q  <= req;
    end else if (rfi) begin
      status_q <= saved_q;
    end else if (csr_wr && status_q[1]) begin
      status_q <= csr_wdata;
    end
  end

  assert_no_take_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (req == '0) |-> !take);
  assert_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!status_q[0] || !instr_done) |-> !take);
  assert_ack_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> ($countones(ack) == 1 && (ack & req) == ack));
  assert_ack_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !take |-> (ack == '0));
  assert_lowest_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> ((req & (ack - NSRC'(1))) == '0));
  assert_push_R6: assert property (@(posedge clk) disable iff (!rst_n)
    push_en == take);
  assert_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (cause == $past(req)));
  assert_cause_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> $stable(cause));
  assert_enter_R9: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (status == 2'b10));
  assert_restore_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rfi && !take) |=> (status == $past(saved_q)));
  assert_user_wr_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_wr && !status[1] && !take && !rfi) |=> $stable(status));
endmodule

// File: tb/tb_irq_vector_unit.sv
module tb_irq_vector_unit;
  localparam int NSRC = 8;
  localparam int XLEN = 32;

  logic clk = 0, rst_n = 0;
  logic [NSRC-1:0] req = '0;
  logic instr_done = 0, rfi = 0, csr_wr = 0;
  logic [XLEN-1:0] pc_next = '0;
  logic [1:0] csr_wdata = '0;
  logic take, push_en;
  logic [NSRC-1:0] ack, cause;
  logic [XLEN-1:0] new_pc, push_data;
  logic [1:0] status;

  int tests = 0, fails = 0;
  logic [2*XLEN+NSRC-1:0] sb[$];

  always #2.5 clk = ~clk;

  irq_vector_unit dut (.*);

  task automatic chk(input string r, input logic [XLEN-1:0] act, exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n && take) begin
    if (sb.size() == 0) begin
      tests++; fails++;
      $display("FAIL R2 actual=take expected=no take");
    end else begin
      logic [2*XLEN+NSRC-1:0] e;
      e = sb.pop_front();
      chk("R3/R4 ack", XLEN'(ack), XLEN'(e[NSRC-1:0]));
      chk("R5 new_pc", new_pc, e[2*XLEN+NSRC-1:XLEN+NSRC]);
      chk("R6/R7 push_data", push_data, e[XLEN+NSRC-1:NSRC]);
      chk("R6 push_en", XLEN'(push_en), 1);
    end
  end

  task automatic fire(input logic [NSRC-1:0] r, input logic done,
                      input logic [XLEN-1:0] pc, input logic expect_take,
                      input logic [XLEN-1:0] vpc, rpc, input logic [NSRC-1:0] a);
    @(posedge clk); #1;
    req = r; instr_done = done; pc_next = pc;
    if (expect_take) sb.push_back({vpc, rpc, a});
    @(negedge clk);
    if (!expect_take) chk("R1/R2 no take", XLEN'(take), 0);
    @(posedge clk); #1;
    req = '0; instr_done = 0;
  endtask

  task automatic pulse_ctl(input logic r, w, input logic [1:0] d);
    @(posedge clk); #1;
    rfi = r; csr_wr = w; csr_wdata = d;
    @(posedge clk); #1;
    rfi = 0; csr_wr = 0;
  endtask

  initial begin
    #200000;
    tests++; fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #12 rst_n = 1;
    @(negedge clk);
    chk("R12 status", XLEN'(status), 2);
    chk("R12 cause", XLEN'(cause), 0);
    fire(8'h04, 1, 32'h100, 0, 0, 0, 0);          // R2 enable clear
    pulse_ctl(0, 1, 2'b11);
    @(negedge clk); chk("R11 sup write", XLEN'(status), 3);
    fire(8'h04, 0, 32'h100, 0, 0, 0, 0);          // R2 no boundary
    fire(8'h00, 1, 32'h100, 0, 0, 0, 0);          // R1 nothing pending
    fire(8'h28, 1, 32'h200, 1, 32'h1030, 32'h200, 8'h08); // R4 R5 R6
    @(negedge clk);
    chk("R9 status", XLEN'(status), 2);
    chk("R8 cause", XLEN'(cause), 32'h28);
    fire(8'h01, 1, 32'h300, 0, 0, 0, 0);          // R9 no nesting
    chk("R8 cause hold", XLEN'(cause), 32'h28);
    pulse_ctl(1, 1, 2'b00);
    @(negedge clk); chk("R10 restore", XLEN'(status), 3);
    fire(8'h86, 1, 32'h400, 1, 32'h1010, 32'h3FC, 8'h02); // R7
    @(negedge clk); chk("R8 multi cause", XLEN'(cause), 32'h86);
    pulse_ctl(0, 1, 2'b01);
    @(negedge clk); chk("R11 to user", XLEN'(status), 1);
    pulse_ctl(0, 1, 2'b00);
    @(negedge clk); chk("R11 user write ignored", XLEN'(status), 1);
    fire(8'h01, 1, 32'h800, 1, 32'h1000, 32'h7FC, 8'h01); // R7 src0
    @(negedge clk); chk("R9 user to sup", XLEN'(status), 2);
    pulse_ctl(1, 0, 2'b00);
    @(negedge clk); chk("R10 back to user", XLEN'(status), 1);
    fire(8'h80, 1, 32'h900, 1, 32'h1070, 32'h900, 8'h80); // R5 top source
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R8 cause idle hold", XLEN'(cause), 32'h80);
    chk("R2 scoreboard drained", XLEN'(sb.size()), 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule